// File: doc/BRIEF.md
# Serial EEPROM Bulk Program Controller

This block is the serial-side controller of a three-wire serial EEPROM. A host frames each instruction by raising chip select, then clocks bits in on the data input. A bit is taken on each rising edge of the serial clock. The controller looks for a start bit, then decodes a two-bit opcode and an address field. After that it either streams a stored word out on the data output or collects a data word.

The memory is a small internal register array. Its reset state is all-ones, which is the erased state. Two bulk instructions program every location in one internal cycle: fill-with-ones and fill-with-a-given-word. In both, the low address bits are don't-care. Single-word read, write and erase share the same decoder.

Programming needs an enable latch that a prior instruction has set. A programming cycle starts only when chip select falls after a complete frame. A cycle counter stands in for the nonvolatile programming time. Once chip select is raised again, the data output shows progress: low while the cycle runs, high when it is over. That status display ends at the next accepted start bit.

All pins are plain control and data lines. The serial protocol has no valid/ready handshake and no back-pressure. The host learns when to continue only from the status level on the data output.

Top module: `uw_bulk_eeprom`

## Requirements
- R1: After reset the data output is 0, the device is ready, programming is disabled, and every location reads all-ones.
- R2: Bits are taken on serial-clock rising edges while chip select is high. Zeros before the first 1 are skipped, and that first 1 is the start bit. Dropping chip select abandons any partial frame.
- R3: Opcode `10` reads. On the edge that takes the last address bit, the output goes to a dummy 0. Each following rising edge then presents the next data bit, most significant bit first.
- R4: Opcode `00` with the two top address bits `11` sets the enable latch, and with `00` clears it. A programming frame sent while the latch is clear changes no location and starts no busy period.
- R5: Opcode `00` with top address bits `10` takes the rest of the address as don't-care and, when enabled, sets every bit of every location to 1.
- R6: Opcode `00` with top address bits `01` takes the rest of the address as don't-care, then DATA_W data bits (MSB first). When enabled, that word is written to every location.
- R7: Opcode `01` plus address plus DATA_W data bits writes one location. Opcode `11` plus address sets one location to all-ones.
- R8: A programming cycle starts on the falling edge of chip select that follows a complete programming frame, and stays busy for PROG_CYCLES clock cycles. If chip select falls before the frame is complete, nothing is programmed.
- R9: After a cycle has started, whenever chip select is high the output is 0 while busy and 1 once ready. This display ends at the next accepted start bit. While chip select is low the output is 0.
- R10: While busy, start bits are ignored, so a whole frame sent during the busy period has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial pins are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, high frames an instruction |
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out: read data or ready/busy status |

## Verification
The bench uses a 16-bit word, a 6-bit address (64 locations) and PROG_CYCLES of 200. With a cycle that long, a complete 25-bit write frame fits inside one busy period, so an instruction can be ignored in full. Sixty-four locations keep the bulk fills cheap to confirm: random reads after every fill land on many locations. The two-bit prefix in the bulk and enable frames is still followed by four don't-care bits, which the bench fills with random values.

// File: rtl/uw_pkg.sv
package uw_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_WRITE,
    OP_ERASE,
    OP_FILL,
    OP_BLANK
  } prog_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_HOLD
  } rx_state_e;
endpackage

// File: rtl/uw_frame_decoder.sv
module uw_frame_decoder
  import uw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sclk,
  input  logic              din,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              prog_go,
  output prog_op_e          prog_op,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              wen,
  output logic              start_seen,
  output logic              rd_active,
  output logic              rd_bit
);
  localparam int MAXF  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAXF + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  rx_state_e         state;
  prog_op_e          op_q;
  logic              sclk_q, cs_q, wen_q;
  logic [1:0]        opc;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_sr;
  logic [DATA_W-1:0] data_sr;
  logic [DATA_W:0]   rd_sr;
  logic              rise, cs_fall;
  logic [ADDR_W-1:0] addr_full;

  assign rise      = cs & sclk & ~sclk_q;
  assign cs_fall   = cs_q & ~cs;
  assign addr_full = {addr_sr[ADDR_W-2:0], din};
  assign rd_addr   = addr_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= OP_NONE;
      wen_q   <= 1'b0;
      opc     <= 2'b00;
      cnt     <= '0;
      addr_sr <= '0;
      data_sr <= '0;
      rd_sr   <= '0;
    end else if (!cs) begin
      state <= ST_IDLE;
      rd_sr <= '0;
    end else if (rise) begin
      unique case (state)
        ST_IDLE: begin
          if (din && !busy) begin
            state <= ST_OPC;
            op_q  <= OP_NONE;
            cnt   <= '0;
          end
        end
        ST_OPC: begin
          opc <= {opc[0], din};
          if (cnt == CNT_W'(1)) begin
            state <= ST_ADDR;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_ADDR: begin
          addr_sr <= addr_full;
          if (cnt == ADDR_LAST) begin
            cnt <= '0;
            unique case (opc)
              2'b10: begin
                rd_sr <= {1'b0, rd_data};
                state <= ST_READ;
              end
              2'b01: begin
                op_q  <= OP_WRITE;
                state <= ST_DATA;
              end
              2'b11: begin
                op_q  <= OP_ERASE;
                state <= ST_HOLD;
              end
              default: begin
                unique case (addr_full[ADDR_W-1 -: 2])
                  2'b11: begin wen_q <= 1'b1; state <= ST_HOLD; end
                  2'b00: begin wen_q <= 1'b0; state <= ST_HOLD; end
                  2'b10: begin op_q <= OP_BLANK; state <= ST_HOLD; end
                  default: begin op_q <= OP_FILL; state <= ST_DATA; end
                endcase
              end
            endcase
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          data_sr <= {data_sr[DATA_W-2:0], din};
          if (cnt == DATA_LAST) state <= ST_HOLD;
          else cnt <= cnt + CNT_W'(1);
        end
        ST_READ: rd_sr <= {rd_sr[DATA_W-1:0], 1'b0};
        default: ;
      endcase
    end
  end

  assign prog_go    = cs_fall && (state == ST_HOLD) && (op_q != OP_NONE) && wen_q;
  assign prog_op    = op_q;
  assign prog_addr  = addr_sr;
  assign prog_data  = data_sr;
  assign wen        = wen_q;
  assign start_seen = rise && (state == ST_IDLE) && din && !busy;
  assign rd_active  = cs && (state == ST_READ);
  assign rd_bit     = rd_sr[DATA_W];

  AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_go); // R10
endmodule

// File: rtl/uw_prog_timer.sv
module uw_prog_timer #(
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left <= '0;
    else if (go)          left <= LOAD;
    else if (left != '0)  left <= left - CW'(1);
  end

  assign busy = (left != '0);

  AST_BUSY_FROM_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go)); // R8
  AST_GO_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy); // R8
endmodule

// File: rtl/uw_reg_array.sv
module uw_reg_array
  import uw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  prog_op_e          op,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '1;
      end else if (go) begin
        if (op == OP_FILL)                                   mem[g] <= wdata;
        else if (op == OP_BLANK)                             mem[g] <= '1;
        else if (op == OP_WRITE && waddr == ADDR_W'(g))      mem[g] <= wdata;
        else if (op == OP_ERASE && waddr == ADDR_W'(g))      mem[g] <= '1;
      end
    end
  end

  assign rdata = mem[raddr];

  AST_BLANK_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_BLANK) |=> (mem[0] == '1 && mem[DEPTH-1] == '1)); // R5
  AST_FILL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_FILL) |=> (mem[0] == $past(wdata) && mem[DEPTH-1] == $past(wdata))); // R6
endmodule

// File: rtl/uw_bulk_eeprom.sv
module uw_bulk_eeprom
  import uw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic din,
  output logic dout
);
  logic              busy, prog_go, wen, start_seen, rd_active, rd_bit;
  prog_op_e          prog_op;
  logic [ADDR_W-1:0] rd_addr, prog_addr;
  logic [DATA_W-1:0] rd_data, prog_data;
  logic              stat_q;

  uw_frame_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din), .busy(busy),
    .rd_data(rd_data), .rd_addr(rd_addr), .prog_go(prog_go), .prog_op(prog_op),
    .prog_addr(prog_addr), .prog_data(prog_data), .wen(wen),
    .start_seen(start_seen), .rd_active(rd_active), .rd_bit(rd_bit)
  );

  uw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .go(prog_go), .busy(busy)
  );

  uw_reg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .go(prog_go), .op(prog_op), .waddr(prog_addr),
    .wdata(prog_data), .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stat_q <= 1'b0;
    else if (prog_go)    stat_q <= 1'b1;
    else if (start_seen) stat_q <= 1'b0;
  end

  always_comb begin
    if (rd_active)          dout = rd_bit;
    else if (cs && stat_q)  dout = ~busy;
    else                    dout = 1'b0;
  end

  AST_GO_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> wen); // R4
  AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_active); // R10
  AST_START_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |-> !busy && !rd_active); // R2
endmodule

// File: tb/sim_uw_bulk_eeprom.sv
module sim_uw_bulk_eeprom;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int PC = 200;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, din = 1'b0;
  logic dout;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_mem [DEPTH];
  bit exp_wen;

  always #2.5 clk = ~clk;

  uw_bulk_eeprom #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din), .dout(dout)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic void model_apply(input int kind, input logic [AW-1:0] a,
                                      input logic [DW-1:0] d);
    if (!exp_wen) return;
    case (kind)
      0: exp_mem[a] = d;
      1: exp_mem[a] = '1;
      2: for (int i = 0; i < DEPTH; i++) exp_mem[i] = d;
      default: for (int i = 0; i < DEPTH; i++) exp_mem[i] = '1;
    endcase
  endfunction

  task automatic sbit(input logic b, output logic o);
    @(negedge clk); din = b; sclk = 1'b0;
    @(negedge clk); sclk = 1'b1;
    @(negedge clk);
    @(negedge clk); o = dout;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic o;
    for (int i = n - 1; i >= 0; i--) sbit(v[i], o);
  endtask

  task automatic cs_up();
    @(negedge clk); cs = 1'b1; sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk); cs = 1'b0; sclk = 1'b0; din = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  // kind: 0 write, 1 erase, 2 fill-all, 3 blank-all, 4 enable, 5 disable
  task automatic frame(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [AW-1:0] fa;
    cs_up();
    fa = {2'b00, a[AW-3:0]};
    case (kind)
      0: begin send(3'b101, 3); send(a, AW); send(d, DW); end
      1: begin send(3'b111, 3); send(a, AW); end
      2: begin fa[AW-1 -: 2] = 2'b01; send(3'b100, 3); send(fa, AW); send(d, DW); end
      3: begin fa[AW-1 -: 2] = 2'b10; send(3'b100, 3); send(fa, AW); end
      4: begin fa[AW-1 -: 2] = 2'b11; send(3'b100, 3); send(fa, AW); end
      default: begin send(3'b100, 3); send(fa, AW); end
    endcase
    cs_down();
  endtask

  task automatic read_check(input logic [AW-1:0] a, input int lead, input string req);
    logic o;
    logic [DW-1:0] got;
    cs_up();
    for (int i = 0; i < lead; i++) sbit(1'b0, o);
    send(3'b110, 3);
    for (int i = AW - 1; i > 0; i--) sbit(a[i], o);
    sbit(a[0], o);
    check({req, " dummy"}, {31'd0, o}, 32'd0);
    for (int i = DW - 1; i >= 0; i--) begin
      sbit(1'b0, o);
      got[i] = o;
    end
    check(req, {16'd0, got}, {16'd0, exp_mem[a]});
    cs_down();
  endtask

  task automatic prog_op(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit en;
    en = exp_wen;
    frame(kind, a, d);
    model_apply(kind, a, d);
    cs_up();
    check("R9 busy low / R4 no status", {31'd0, dout}, 32'd0);
    if (en) begin
      repeat (PC + 5) @(negedge clk);
      check("R9 ready high", {31'd0, dout}, 32'd1);
    end
    cs_down();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic o;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '1;
    exp_wen = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 dout after reset", {31'd0, dout}, 32'd0);
    read_check(6'd0, 0, "R1 reset contents");
    read_check(6'd63, 2, "R2 leading zeros / R1");

    // R4: disabled programming has no effect
    prog_op(0, 6'd5, 16'h1234);
    read_check(6'd5, 0, "R4 write while disabled");
    frame(4, 6'd0, '0); exp_wen = 1'b1;

    // R7 single write / erase
    prog_op(0, 6'd5, 16'hA5C3);
    read_check(6'd5, 0, "R7 single write");
    read_check(6'd6, 0, "R7 neighbour untouched");
    prog_op(1, 6'd5, '0);
    read_check(6'd5, 0, "R7 single erase");

    // R6 fill all, R5 blank all
    prog_op(2, 6'h2A, 16'h3C5A);
    read_check(6'd0, 0, "R6 fill first");
    read_check(6'd63, 0, "R6 fill last");
    prog_op(3, 6'h15, '0);
    read_check(6'd17, 0, "R5 blank");

    // R8 abort mid frame
    cs_up(); send(3'b101, 3); send(6'd9, AW); send(8'h00, 8); cs_down();
    cs_up();
    check("R8 abort no busy", {31'd0, dout}, 32'd0);
    cs_down();
    read_check(6'd9, 0, "R8 abort no write");

    // R10 frame during busy ignored; R9 status cleared by start bit
    frame(0, 6'd9, 16'h0F0F); model_apply(0, 6'd9, 16'h0F0F);
    frame(0, 6'd10, 16'h7777);
    cs_up();
    check("R9 still busy", {31'd0, dout}, 32'd0);
    repeat (PC) @(negedge clk);
    check("R9 ready after cycle", {31'd0, dout}, 32'd1);
    sbit(1'b1, o);
    check("R9 status cleared by start", {31'd0, o}, 32'd0);
    cs_down();
    read_check(6'd10, 0, "R10 busy frame ignored");
    read_check(6'd9, 0, "R7 write before busy frame");

    // R4 disable again
    frame(5, 6'd0, '0); exp_wen = 1'b0;
    prog_op(3, 6'd0, '0);
    read_check(6'd9, 0, "R4 blank while disabled");
    frame(4, 6'd0, '0); exp_wen = 1'b1;

    // constrained random mix
    for (int n = 0; n < 14; n++) begin
      int k;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      k = int'($urandom_range(0, 4));
      a = AW'($urandom);
      d = DW'($urandom);
      if (k == 4) begin
        if (exp_wen) begin frame(5, a, d); exp_wen = 1'b0; end
        else begin frame(4, a, d); exp_wen = 1'b1; end
      end else begin
        prog_op(k, a, d);
      end
      for (int r = 0; r < 3; r++)
        read_check(AW'($urandom), int'($urandom_range(0, 2)), "R3 random read");
      read_check(a, 0, "R3 random target read");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule